// File: doc/BRIEF.md
# Multi-Speed Data-Strobe Serial Transmitter

This block takes parallel transmit data from a link-layer interface and sends it out as a serial data-strobe pair. A single fast bit clock drives it. An internal divide-by-eight counter marks the slower system-clock rate, and `sys_tick` is high in the last bit clock of each system period. On the edge that ends a tick cycle the block captures one group from `tx_data`. The group is two, four or eight bits wide, depending on the speed code.

The captured bits go out most significant bit first, one per 4, 2 or 1 bit clocks. This gives serial rates of 2x, 4x and 8x the system rate. The data line carries each bit as it is. The strobe line toggles only when a bit repeats the one before it, so exactly one of the two lines changes at each bit boundary. The speed code is taken once, at packet start, and stays fixed until the packet ends. A packet ends at a system tick where the transmit enable is low. While no packet is in flight, both drive enables are low and both lines read 0.

Top module: `ds_serializer_tx`

## Requirements
- R1: `sys_tick` is high for exactly one bit clock in every eight. The first tick after reset is the eighth bit clock. Inputs are captured on the rising edge that ends a tick cycle.
- R2: Speed code 2'b00 (lowest rate) takes 2 bits per group and holds each bit for 4 bit clocks. Code 2'b01 takes 4 bits and holds each for 2 bit clocks. Code 2'b10 takes 8 bits and holds each for 1 bit clock. Code 2'b11 behaves exactly like 2'b10.
- R3: Bits of a group are sent starting from `tx_data[7]` and moving downward. Bits below the ones the speed uses have no effect on the lines.
- R4: `line_d` equals the bit currently sent. At each bit boundary, `line_s` inverts if the new bit equals the previous bit and holds otherwise. Exactly one of the two lines changes at every boundary inside a packet.
- R5: At packet start, the previous data and strobe are taken as 0. A first bit of 0 gives `line_s`=1, and a first bit of 1 gives `line_s`=0.
- R6: A packet starts only on a tick edge with `tx_en` high. The first bit appears in the bit clock right after that edge. Raising `tx_en` between ticks changes nothing until the next tick edge.
- R7: The speed code is sampled only at packet start. Changes on `tx_speed` during a packet do not alter the bit timing.
- R8: A packet stops only on a tick edge with `tx_en` low, so whole groups are always sent. After that edge both enables are low and both lines are 0.
- R9: In reset and whenever no packet is active, `line_d_en` and `line_s_en` are low and `line_d` and `line_s` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, eight times the system rate |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit request, sampled at system ticks |
| tx_speed | input | 2 | Speed code, sampled at packet start |
| tx_data | input | 8 | Parallel group, MSB-aligned |
| sys_tick | output | 1 | High in the last bit clock of each system period |
| line_d | output | 1 | Encoded data line |
| line_d_en | output | 1 | Drive enable for the data line |
| line_s | output | 1 | Encoded strobe line |
| line_s_en | output | 1 | Drive enable for the strobe line |

## Verification
The assertions assume that `tx_en`, `tx_speed` and `tx_data` change only away from the rising edge. They also assume a packet's group and request are valid by the end of a tick cycle. The stimulus meets this by driving every input on falling edges only. It loads each new group and the stop request in the falling edge where `sys_tick` is high. It also disturbs `tx_speed` in the middle of groups, and it sets `tx_en` between ticks, to show that such changes take effect only at the places R6 and R7 allow.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'b00,
    SPD_MID  = 2'b01,
    SPD_HIGH = 2'b10,
    SPD_ALT  = 2'b11
  } speed_t;

  // log2 of the number of bit clocks each bit is held for
  function automatic logic [1:0] rate_shift(input logic [1:0] code);
    case (speed_t'(code))
      SPD_LOW: return 2'd2;
      SPD_MID: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // strobe flips only when the data bit repeats
  function automatic logic strobe_next(input logic new_d, input logic prev_d,
                                       input logic prev_s);
    return (new_d == prev_d) ? ~prev_s : prev_s;
  endfunction

endpackage

// File: rtl/ds_tx_phase.sv
module ds_tx_phase #(
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned PH_W = $clog2(GROUP_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_nxt,
  output logic            sys_tick
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_nxt;
  end

  assign ph_nxt   = ph_q + 1'b1;
  assign sys_tick = (ph_q == PH_W'(GROUP_W - 1));
endmodule

// File: rtl/ds_tx_ctrl.sv
module ds_tx_ctrl
  import ds_tx_pkg::*;
#(
  parameter int unsigned GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sys_tick,
  input  logic               tx_en,
  input  logic [1:0]         tx_speed,
  input  logic [GROUP_W-1:0] tx_data,
  output logic               run,
  output logic               start_evt,
  output logic               active,
  output logic [1:0]         spd_q,
  output logic [1:0]         shift,
  output logic [GROUP_W-1:0] src
);
  logic [GROUP_W-1:0] grp_q;

  always_comb begin
    start_evt = sys_tick && tx_en && !active;
    run       = sys_tick ? tx_en : active;
    shift     = rate_shift(start_evt ? tx_speed : spd_q);
    src       = sys_tick ? tx_data : grp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      spd_q  <= 2'b00;
      grp_q  <= '0;
    end else if (sys_tick) begin
      active <= tx_en;
      grp_q  <= tx_data;
      if (start_evt) spd_q <= tx_speed;
    end
  end
endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
  import ds_tx_pkg::*;
#(
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned PH_W = $clog2(GROUP_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               start_evt,
  input  logic [PH_W-1:0]    ph_nxt,
  input  logic [1:0]         shift,
  input  logic [GROUP_W-1:0] src,
  output logic               line_d,
  output logic               line_s,
  output logic               drv_en,
  output logic               bit_adv
);
  logic [PH_W-1:0] hold_mask;
  logic [PH_W-1:0] idx;
  logic            boundary;
  logic            new_bit;
  logic            prev_d;
  logic            prev_s;

  always_comb begin
    hold_mask = ~({PH_W{1'b1}} << shift);
    boundary  = ((ph_nxt & hold_mask) == '0);
    idx       = PH_W'(GROUP_W - 1) - (ph_nxt >> shift);
    new_bit   = src[idx];
    prev_d    = start_evt ? 1'b0 : line_d;
    prev_s    = start_evt ? 1'b0 : line_s;
    bit_adv   = run && boundary && !start_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      line_d <= 1'b0;
      line_s <= 1'b0;
      drv_en <= 1'b0;
    end else begin
      drv_en <= 1'b1;
      if (boundary) begin
        line_d <= new_bit;
        line_s <= strobe_next(new_bit, prev_d, prev_s);
      end
    end
  end
endmodule

// File: rtl/ds_serializer_tx.sv
module ds_serializer_tx #(
  parameter int unsigned GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [1:0]         tx_speed,
  input  logic [GROUP_W-1:0] tx_data,
  output logic               sys_tick,
  output logic               line_d,
  output logic               line_d_en,
  output logic               line_s,
  output logic               line_s_en
);
  localparam int unsigned PH_W = $clog2(GROUP_W);

  logic [PH_W-1:0]    ph_nxt;
  logic               run;
  logic               start_evt;
  logic               active;
  logic [1:0]         spd_q;
  logic [1:0]         shift;
  logic [GROUP_W-1:0] src;
  logic               drv_en;
  logic               bit_adv;

  ds_tx_phase #(.GROUP_W(GROUP_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .sys_tick(sys_tick)
  );

  ds_tx_ctrl #(.GROUP_W(GROUP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .tx_en(tx_en),
    .tx_speed(tx_speed), .tx_data(tx_data), .run(run),
    .start_evt(start_evt), .active(active), .spd_q(spd_q),
    .shift(shift), .src(src)
  );

  ds_tx_encoder #(.GROUP_W(GROUP_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .run(run), .start_evt(start_evt),
    .ph_nxt(ph_nxt), .shift(shift), .src(src), .line_d(line_d),
    .line_s(line_s), .drv_en(drv_en), .bit_adv(bit_adv)
  );

  assign line_d_en = drv_en;
  assign line_s_en = drv_en;
endmodule

// File: rtl/ds_tx_checker.sv
module ds_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_tick,
  input logic       start_evt,
  input logic       bit_adv,
  input logic       active,
  input logic [1:0] spd_q,
  input logic       line_d,
  input logic       line_s,
  input logic       line_d_en
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick |=> !sys_tick); // R1

  AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    bit_adv |=> ($countones({line_d ^ $past(line_d), line_s ^ $past(line_s)}) == 1)); // R4

  AST_HOLD_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sys_tick && !bit_adv) |=> ($stable(line_d) && $stable(line_s))); // R2

  AST_START_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> line_d_en); // R6

  AST_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_d_en) |-> $past(sys_tick)); // R6

  AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sys_tick) |=> $stable(spd_q)); // R7

  AST_STOP_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_d_en) |-> $past(sys_tick)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !line_d_en |-> (!line_d && !line_s)); // R9
endmodule

bind ds_serializer_tx ds_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .start_evt(start_evt),
  .bit_adv(bit_adv), .active(active), .spd_q(spd_q), .line_d(line_d),
  .line_s(line_s), .line_d_en(line_d_en)
);

// File: tb/ds_serializer_tx_bench.sv
module ds_serializer_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] tx_speed = 2'b00;
  logic [7:0] tx_data = 8'h00;
  logic       sys_tick, line_d, line_d_en, line_s, line_s_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] grp [4];

  always #2.5 clk = ~clk;

  ds_serializer_tx u_ds_serializer_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_speed(tx_speed),
    .tx_data(tx_data), .sys_tick(sys_tick), .line_d(line_d),
    .line_d_en(line_d_en), .line_s(line_s), .line_s_en(line_s_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check({line_d_en, line_s_en, line_d, line_s} == 4'b0000, req,
          {line_d_en, line_s_en, line_d, line_s}, 0);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!sys_tick);
  endtask

  // Caller is at a falling edge with sys_tick high. Sends n groups from grp[].
  task automatic run_groups(input logic [1:0] spd, input int n, input logic [1:0] noise,
                            input string req);
    int sh;
    logic ed, es, b;
    sh = (spd == 2'b00) ? 2 : (spd == 2'b01) ? 1 : 0;
    ed = 1'b0; es = 1'b0;
    tx_en = 1'b1; tx_speed = spd; tx_data = grp[0];
    for (int g = 0; g < n; g++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if ((c & ((1 << sh) - 1)) == 0) begin
          b  = grp[g][7 - (c >> sh)];
          es = (b == ed) ? ~es : es;
          ed = b;
        end
        check(line_d_en && line_s_en, {req, " R6 enables"}, {line_d_en, line_s_en}, 3);
        check(line_d == ed, {req, " R3 data"}, line_d, ed);
        check(line_s == es, {req, " R4 strobe"}, line_s, es);
        if (c == 3) tx_speed = noise;   // R7 disturbance
        if (c == 7) begin
          check(sys_tick, {req, " R1 tick"}, sys_tick, 1);
          if (g + 1 < n) tx_data = grp[g + 1];
          else tx_en = 1'b0;
        end
      end
    end
    @(negedge clk);
    check_idle({req, " R8 stop"});
    tx_speed = 2'b00;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_idle("R9 in reset");
    rst_n = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check(sys_tick == (i == 7), "R1 first tick", sys_tick, (i == 7));
    end
  endtask

  task automatic t_idle();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check_idle("R9 idle without request");
    end
  endtask

  task automatic t_s400();
    grp[0] = 8'hB4; grp[1] = 8'h0F; grp[2] = 8'hE1;
    wait_tick();
    run_groups(2'b10, 3, 2'b00, "R2 high rate");
  endtask

  task automatic t_s200();
    grp[0] = 8'h9C; grp[1] = 8'h3A;
    wait_tick();
    run_groups(2'b01, 2, 2'b10, "R7 mid rate held");
  endtask

  task automatic t_s100();
    grp[0] = 8'h5F; grp[1] = 8'hC0; grp[2] = 8'h3A;
    wait_tick();
    run_groups(2'b00, 3, 2'b10, "R3 low rate lower bits ignored");
  endtask

  task automatic t_alt_code();
    grp[0] = 8'h6D;
    wait_tick();
    run_groups(2'b11, 1, 2'b00, "R2 code 3 as high rate");
  endtask

  task automatic t_first_bit();
    grp[0] = 8'h00;  // first bit 0 -> strobe 1, toggles every bit
    wait_tick();
    run_groups(2'b10, 1, 2'b10, "R5 zeros");
    grp[0] = 8'hFF;  // first bit 1 -> strobe 0
    wait_tick();
    run_groups(2'b10, 1, 2'b10, "R5 ones");
    grp[0] = 8'hAA;  // alternating: strobe never moves after first bit
    wait_tick();
    run_groups(2'b10, 1, 2'b10, "R4 alternating");
  endtask

  task automatic t_late_start();
    wait_tick();
    @(negedge clk);
    tx_en = 1'b1; tx_speed = 2'b01; tx_data = 8'hF0;
    while (!sys_tick) begin
      check_idle("R6 request between ticks");
      @(negedge clk);
    end
    grp[0] = 8'hF0;
    run_groups(2'b01, 1, 2'b01, "R6 late start");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_s400();
    t_s200();
    t_s100();
    t_alt_code();
    t_first_bit();
    t_late_start();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule